// File: doc/BRIEF.md
# Unlock-Sequence Command Detector

This block sits beside the bus interface of a byte-wide static memory with a 13-bit address. It watches every selected bus cycle and looks for a fixed run of six read addresses. A memory controller can then ask for a nonvolatile save or a restore using only ordinary reads, with no extra command pins. The last address of the run selects the command. One value asks for the memory contents to be saved into the nonvolatile store. A neighbouring value asks for the contents to be restored from it.

The detector does not move any data itself. It gives the store/recall engine a one-clock request pulse. On the command cycle it also raises a flag that tells the bus interface to hold its data pins in high impedance. The first five cycles of the run are ordinary reads. Any of the following drops the partial run: a write, an address out of order, or a busy indication from the engine. Cycles with the chip deselected, and clocks with no bus strobe, leave the partial run untouched.

Top module: `seqcmd_detector`

## Requirements
- R1: After a synchronous active-low reset, `store_req`, `recall_req` and `data_hiz` are low, and the matcher waits for the first address of the run.
- R2: The run is six selected read cycles. The first five addresses, in order, are 0x0000, 0x1555, 0x0AAA, 0x1FFF and 0x10F0. A sixth address of 0x0F0F makes `store_req` high for exactly one clock, starting in the cycle after the sixth cycle is sampled.
- R3: The same five leading addresses followed by 0x0F0E make `recall_req` high for exactly one clock, in the cycle after the sixth cycle is sampled.
- R4: `data_hiz` is high, combinationally, only during a selected read cycle that completes a valid run (sixth address 0x0F0F or 0x0F0E). It stays low on the five leading cycles and on every other cycle.
- R5: A selected cycle with `we_n` low drops any partial run, and produces no request and no `data_hiz` on that cycle.
- R6: A selected read whose address is not the next expected value drops the partial run. If that address is 0x0000, it counts as the first step of a new run.
- R7: Cycles with `ce_n` high, and clocks with `cyc_valid` low, neither advance nor reset the partial run.
- R8: While `busy` is high, no request and no `data_hiz` is produced, and any partial run is dropped.
- R9: `store_req` and `recall_req` are never high together, and neither stays high for two clocks in a row.
- R10: A sixth address other than the two command values produces no request. It restarts the matcher under the rule in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_valid | input | 1 | High on the clock that samples one bus cycle |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low (high = read) |
| addr | input | 13 | Bus address of the cycle |
| busy | input | 1 | Store/recall engine is working |
| store_req | output | 1 | One-clock request to save into the nonvolatile store |
| recall_req | output | 1 | One-clock request to restore from the nonvolatile store |
| data_hiz | output | 1 | Hold data pins in high impedance on this cycle |

## Verification
The hardest cases to reach from the ports are the ones where a run survives interruptions, or restarts inside itself. Examples are a run with deselected cycles and idle clocks between its steps, and a run broken by 0x0000 in mid-sequence, which must count as the first step of a new run. The directed runs place these interruptions at every depth of the sequence. A busy pulse or a write is placed on the final cycle itself, and a neighbouring wrong final address is tried.

A long random stream is mostly built from the unlock addresses, so that partial and complete runs happen often. It is compared against a step-counting reference model on every clock.

// File: rtl/seqcmd_pkg.sv
// Package: shared constants and types for the unlock-sequence detector.
// Assumes: the leading addresses of the run fit in 16 bits and are
// truncated to the address width by the user.
package seqcmd_pkg;

    // Command decoded from the final address of a run.
    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_STORE  = 2'd1,
        CMD_RECALL = 2'd2
    } seq_cmd_e;

    // Number of addresses that precede the command address.
    localparam int PREFIX_LEN = 5;

    // Leading address of the run at position idx (0 = first).
    function automatic logic [15:0] prefix_addr(input int idx);
        logic [15:0] v;
        case (idx)
            0:       v = 16'h0000;
            1:       v = 16'h1555;
            2:       v = 16'h0AAA;
            3:       v = 16'h1FFF;
            4:       v = 16'h10F0;
            default: v = 16'h0000;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/seqcmd_addr_cmp.sv
// Module: address comparator bank.
// Compares the current address with every leading address of the run,
// in parallel, and with the two command addresses.
// Assumes: step counts the leading addresses already matched
// (0..PREFIX_LEN).
module seqcmd_addr_cmp #(
    parameter int              ADDR_W      = 13,
    parameter int              STEP_W      = 3,
    parameter logic [ADDR_W-1:0] STORE_ADDR  = 13'h0F0F,
    parameter logic [ADDR_W-1:0] RECALL_ADDR = 13'h0F0E
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic [STEP_W-1:0]      step,
    output logic                   prefix_hit,
    output logic                   is_start,
    output seqcmd_pkg::seq_cmd_e   cmd
);
    localparam int NPFX = seqcmd_pkg::PREFIX_LEN;

    logic [NPFX-1:0] pfx_eq;

    // One equality comparator per leading address.
    for (genvar g = 0; g < NPFX; g++) begin : g_pfx
        localparam logic [ADDR_W-1:0] EXP = ADDR_W'(seqcmd_pkg::prefix_addr(g));
        assign pfx_eq[g] = (addr == EXP);
    end

    // Select the comparator that belongs to the current step.
    always_comb begin
        prefix_hit = 1'b0;
        for (int i = 0; i < NPFX; i++) begin
            if (step == STEP_W'(i)) prefix_hit = pfx_eq[i];
        end
    end

    // The first leading address starts a new run from any state.
    assign is_start = pfx_eq[0];

    // Decode the final address into a command.
    always_comb begin
        if (addr == STORE_ADDR)       cmd = seqcmd_pkg::CMD_STORE;
        else if (addr == RECALL_ADDR) cmd = seqcmd_pkg::CMD_RECALL;
        else                          cmd = seqcmd_pkg::CMD_NONE;
    end

endmodule

// File: rtl/seqcmd_step_ctr.sv
// Module: run progress counter.
// Tracks how many leading addresses of the run have been matched.
// Fires when a selected read completes the run with a command address.
// Assumes: sel is high only for a sampled cycle with the chip enabled.
module seqcmd_step_ctr #(
    parameter int STEP_W = 3,
    parameter int LAST   = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel,
    input  logic                  is_read,
    input  logic                  busy,
    input  logic                  prefix_hit,
    input  logic                  is_start,
    input  seqcmd_pkg::seq_cmd_e  cmd,
    output logic                  fire,
    output logic [STEP_W-1:0]     step
);
    logic              at_last;
    logic [STEP_W-1:0] step_nxt;

    assign at_last = (step == STEP_W'(LAST));

    // Completion of a run on the current cycle.
    assign fire = sel && is_read && !busy && at_last &&
                  (cmd != seqcmd_pkg::CMD_NONE);

    // Next progress value for a selected cycle.
    always_comb begin
        step_nxt = step;
        if (sel) begin
            if (busy || !is_read) begin
                step_nxt = '0;
            end else if (fire) begin
                step_nxt = '0;
            end else if (!at_last && prefix_hit) begin
                step_nxt = step + 1'b1;
            end else if (is_start) begin
                step_nxt = STEP_W'(1);
            end else begin
                step_nxt = '0;
            end
        end
    end

    // Progress register.
    always_ff @(posedge clk) begin
        if (!rst_n) step <= '0;
        else        step <= step_nxt;
    end

endmodule

// File: rtl/seqcmd_req_gen.sv
// Module: request pulse generator.
// Turns a completed run into a one-clock store or recall pulse in the
// next cycle.
// Assumes: fire is high for at most one clock per run.
module seqcmd_req_gen (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fire,
    input  seqcmd_pkg::seq_cmd_e  cmd,
    output logic                  store_req,
    output logic                  recall_req
);
    // Register the pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_req  <= 1'b0;
            recall_req <= 1'b0;
        end else begin
            store_req  <= fire && (cmd == seqcmd_pkg::CMD_STORE);
            recall_req <= fire && (cmd == seqcmd_pkg::CMD_RECALL);
        end
    end

endmodule

// File: rtl/seqcmd_detector.sv
// Module: top of the unlock-sequence command detector.
// Watches selected bus cycles and recognises the six-address run that
// asks for a save or a restore. Raises data_hiz during the command cycle
// and pulses a request one clock later.
// Assumes: one bus cycle per clock with cyc_valid high; busy comes from
// the store/recall engine.
module seqcmd_detector #(
    parameter int              ADDR_W      = 13,
    parameter logic [ADDR_W-1:0] STORE_ADDR  = 13'h0F0F,
    parameter logic [ADDR_W-1:0] RECALL_ADDR = 13'h0F0E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_valid,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy,
    output logic              store_req,
    output logic              recall_req,
    output logic              data_hiz
);
    localparam int LAST   = seqcmd_pkg::PREFIX_LEN;
    localparam int STEP_W = $clog2(LAST + 1);

    logic                 sel;
    logic                 prefix_hit;
    logic                 is_start;
    logic                 fire;
    logic [STEP_W-1:0]    step;
    seqcmd_pkg::seq_cmd_e cmd;

    // A bus cycle counts only when it is sampled and the chip is enabled.
    assign sel = cyc_valid && !ce_n;

    seqcmd_addr_cmp #(
        .ADDR_W(ADDR_W), .STEP_W(STEP_W),
        .STORE_ADDR(STORE_ADDR), .RECALL_ADDR(RECALL_ADDR)
    ) u_cmp (
        .addr(addr), .step(step), .prefix_hit(prefix_hit),
        .is_start(is_start), .cmd(cmd)
    );

    seqcmd_step_ctr #(.STEP_W(STEP_W), .LAST(LAST)) u_ctr (
        .clk(clk), .rst_n(rst_n), .sel(sel), .is_read(we_n), .busy(busy),
        .prefix_hit(prefix_hit), .is_start(is_start), .cmd(cmd),
        .fire(fire), .step(step)
    );

    seqcmd_req_gen u_req (
        .clk(clk), .rst_n(rst_n), .fire(fire), .cmd(cmd),
        .store_req(store_req), .recall_req(recall_req)
    );

    // The command cycle floats the data pins.
    assign data_hiz = fire;

endmodule

// File: rtl/seqcmd_detector_chk.sv
// Module: assertion checker for seqcmd_detector, attached by bind.
// Assumes: it sees the top-level ports only.
module seqcmd_detector_chk (
    input logic clk,
    input logic rst_n,
    input logic cyc_valid,
    input logic ce_n,
    input logic we_n,
    input logic busy,
    input logic store_req,
    input logic recall_req,
    input logic data_hiz
);
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_req && recall_req));

    a_r9_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req || recall_req) |=> !(store_req || recall_req));

    a_r2_req_after_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req || recall_req) |-> $past(data_hiz));

    a_r4_hiz_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        data_hiz |-> (cyc_valid && !ce_n && we_n));

    a_r5_write_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && !ce_n && !we_n) |=> !(store_req || recall_req));

    a_r7_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !(cyc_valid && !ce_n) |=> !(store_req || recall_req));

    a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !data_hiz);

endmodule

bind seqcmd_detector seqcmd_detector_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .ce_n(ce_n),
    .we_n(we_n), .busy(busy), .store_req(store_req),
    .recall_req(recall_req), .data_hiz(data_hiz)
);

// File: tb/seqcmd_detector_bench.sv
// Bench: behavioural reference model compared on every clock.
module seqcmd_detector_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_valid = 1'b0;
    logic        ce_n = 1'b1;
    logic        we_n = 1'b1;
    logic [12:0] addr = '0;
    logic        busy = 1'b0;
    logic        store_req, recall_req, data_hiz;

    int checks = 0;
    int bad = 0;
    bit finished = 0;

    // Reference model state.
    int unsigned lead[$] = '{32'h0000, 32'h1555, 32'h0AAA, 32'h1FFF, 32'h10F0};
    int m_step = 0;
    bit exp_st = 0, exp_rc = 0;

    seqcmd_detector u_seqcmd_detector (
        .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .ce_n(ce_n),
        .we_n(we_n), .addr(addr), .busy(busy), .store_req(store_req),
        .recall_req(recall_req), .data_hiz(data_hiz)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input string what,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t",
                     tag, what, act, exp, $time);
        end
    endtask

    function automatic bit model_hiz(input bit v, input bit c, input bit w,
                                     input int unsigned a, input bit b);
        return v && !c && w && !b && (m_step == 5) &&
               (a == 32'h0F0F || a == 32'h0F0E);
    endfunction

    // One clock: drive at the falling edge, compare, then advance the model.
    task automatic bus(input bit v, input bit c, input bit w,
                       input int unsigned a, input bit b, input string tag);
        bit h;
        @(negedge clk);
        cyc_valid = v; ce_n = c; we_n = w; addr = a[12:0]; busy = b;
        #1;
        h = model_hiz(v, c, w, a, b);
        check(tag, "data_hiz", data_hiz, h);
        check(tag, "store_req", store_req, exp_st);
        check(tag, "recall_req", recall_req, exp_rc);
        check("R9", "pair", store_req && recall_req, 1'b0);
        @(posedge clk);
        exp_st = h && (a == 32'h0F0F);
        exp_rc = h && (a == 32'h0F0E);
        if (v && !c) begin
            if (b || !w || h)                           m_step = 0;
            else if (m_step < 5 && a == lead[m_step])   m_step++;
            else if (a == 32'h0000)                     m_step = 1;
            else                                        m_step = 0;
        end
    endtask

    task automatic rd(input int unsigned a, input string tag);
        bus(1, 0, 1, a, 0, tag);
    endtask

    task automatic run(input int unsigned last, input string tag);
        foreach (lead[i]) rd(lead[i], tag);
        rd(last, tag);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            bad++;
            checks++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        #1;
        check("R1", "store_req", store_req, 1'b0);
        check("R1", "recall_req", recall_req, 1'b0);
        check("R1", "data_hiz", data_hiz, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 store run, then idle so the pulse is seen and then gone.
        run(32'h0F0F, "R2");
        bus(0, 1, 1, 0, 0, "R2");
        bus(0, 1, 1, 0, 0, "R9");
        // R3 recall run.
        run(32'h0F0E, "R3");
        bus(0, 1, 1, 0, 0, "R3");
        bus(0, 1, 1, 0, 0, "R9");
        // R4 back-to-back runs.
        run(32'h0F0F, "R4");
        run(32'h0F0E, "R4");
        bus(0, 1, 1, 0, 0, "R4");
        // R5 write in mid-run and on the final cycle.
        rd(32'h0000, "R5"); rd(32'h1555, "R5"); rd(32'h0AAA, "R5");
        bus(1, 0, 0, 32'h1FFF, 0, "R5");
        rd(32'h10F0, "R5"); rd(32'h0F0F, "R5");
        foreach (lead[i]) rd(lead[i], "R5");
        bus(1, 0, 0, 32'h0F0F, 0, "R5");
        bus(0, 1, 1, 0, 0, "R5");
        // R6 wrong address, then restart via 0x0000 in mid-run.
        rd(32'h0000, "R6"); rd(32'h1554, "R6"); rd(32'h0AAA, "R6");
        rd(32'h0000, "R6"); rd(32'h1555, "R6"); rd(32'h0AAA, "R6");
        rd(32'h0000, "R6");
        rd(32'h1555, "R6"); rd(32'h0AAA, "R6"); rd(32'h1FFF, "R6");
        rd(32'h10F0, "R6"); rd(32'h0F0F, "R6");
        rd(32'h0000, "R6"); rd(32'h0000, "R6");
        run(32'h0F0E, "R6");
        bus(0, 1, 1, 0, 0, "R6");
        // R7 deselected and idle clocks between every step.
        foreach (lead[i]) begin
            rd(lead[i], "R7");
            bus(1, 1, 0, 32'h1234, 0, "R7");
            bus(0, 0, 0, 32'h0000, 0, "R7");
        end
        rd(32'h0F0F, "R7");
        bus(0, 1, 1, 0, 0, "R7");
        // R8 busy in mid-run and on the final cycle.
        rd(32'h0000, "R8"); rd(32'h1555, "R8");
        bus(1, 0, 1, 32'h0AAA, 1, "R8");
        rd(32'h1FFF, "R8"); rd(32'h10F0, "R8"); rd(32'h0F0F, "R8");
        foreach (lead[i]) rd(lead[i], "R8");
        bus(1, 0, 1, 32'h0F0E, 1, "R8");
        bus(0, 1, 1, 0, 0, "R8");
        // R10 neighbouring wrong final addresses.
        run(32'h0F0D, "R10");
        run(32'h0F1F, "R10");
        run(32'h0000, "R10");
        rd(32'h1555, "R10"); rd(32'h0AAA, "R10"); rd(32'h1FFF, "R10");
        rd(32'h10F0, "R10"); rd(32'h0F0F, "R10");
        bus(0, 1, 1, 0, 0, "R10");

        // Random stream biased toward the unlock addresses.
        for (int n = 0; n < 4000; n++) begin
            int unsigned pick, a;
            pick = $urandom_range(0, 19);
            if (pick < 5)       a = lead[pick];
            else if (pick < 13) a = lead[m_step < 5 ? m_step : 0];
            else if (pick < 16) a = (pick[0]) ? 32'h0F0F : 32'h0F0E;
            else                a = $urandom_range(0, 8191);
            if (m_step == 5 && pick < 12) a = (pick[0]) ? 32'h0F0F : 32'h0F0E;
            bus($urandom_range(0, 9) != 0, $urandom_range(0, 9) == 0,
                $urandom_range(0, 19) != 0, a, $urandom_range(0, 29) == 0,
                "R6");
        end
        bus(0, 1, 1, 0, 0, "R9");

        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule